// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Per-Pin Interrupt Detection

The block is an 8-pin general-purpose port that sits on a simple single-cycle register bus. Software sets each pin as an input or an output, writes output values and reads back the pin states. Every pin can also raise an interrupt. Each pin has two configuration bits: a kind bit that picks level or edge detection, and a polarity bit that picks low/falling or high/rising.

Pin inputs pass through a two-stage synchroniser before any detection. Level interrupts follow the synchronised pin directly. An edge event is held in a per-pin latch until software writes a one to that pin's bit in the acknowledge register. A per-pin enable gates what leaves the block. The port drives one output per pin and one OR-combined request.

The bus has no wait states. A write lands on the next clock edge. Read data is a combinational function of the address and the current register state.

Top module: `gpio_irq_port`

## Requirements
- R1: A change on `pin_i` becomes visible in the block after two clock edges. It cannot be seen after only one.
- R2: A pin whose kind bit is 0 reports a level interrupt while its synchronised value equals its polarity bit. Polarity 1 means active high and polarity 0 means active low.
- R3: A pin whose kind bit is 1 latches an event when its synchronised value rises (polarity 1) or falls (polarity 0). The event stays set after the pin returns. It is visible on the third clock edge after the pin changes.
- R4: Writing a 1 to a bit of the acknowledge register (address 7) clears that pin's latched event. If a new edge is detected in the same cycle, the event stays set.
- R5: A write to the kind register (address 2) or the polarity register (address 3) that changes a pin's bit clears that pin's latched event. This has priority over a new edge in the same cycle.
- R6: `irq_pin_o[i]` is the pin's pending condition ANDed with its enable bit (register at address 4). A disabled pin never reports.
- R7: `irq_o` is high exactly when any bit of `irq_pin_o` is high.
- R8: `pin_oe` equals the direction register (address 1, where 1 means output), and `pin_o` equals the output register (address 0). Both update on the edge that takes the write.
- R9: Reading address 0 returns the output register bit for output pins and the synchronised pin value for input pins.
- R10: Reads return the registers at addresses 1 to 4. Address 5 returns the raw pending bits, address 6 returns raw pending ANDed with enable, and address 7 returns 0. `bus_rdata` is 0 while `bus_sel` is low.
- R11: After reset, all configuration registers, event latches and synchroniser stages are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_i | input | 8 | Pin levels from the pads |
| pin_o | output | 8 | Output values toward the pads |
| pin_oe | output | 8 | Per-pin output enable |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| irq_o | output | 1 | OR of all per-pin requests |
| irq_pin_o | output | 8 | Per-pin interrupt requests |

## Verification
Three events can collide on the same clock edge: a freshly synchronised edge, a write-one-to-clear acknowledge, and a type change for the same pin. The bench provokes each pairing directly. It times a pin transition so that the edge is detected on exactly the edge that takes an acknowledge write. In a long stretch of pseudo-random traffic, it mixes kind and polarity writes with pin toggling. A behavioural per-pin model applies the stated priority (type change first, then new edge, then acknowledge). The bench compares the interrupt outputs and the read data against that model on every cycle.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA = 3'd0,
    REG_DIR  = 3'd1,
    REG_KIND = 3'd2,
    REG_POL  = 3'd3,
    REG_IEN  = 3'd4,
    REG_RAW  = 3'd5,
    REG_STAT = 3'd6,
    REG_ACK  = 3'd7
  } reg_addr_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];
  logic [W-1:0] stg_d [STAGES];

  always_comb begin
    stg_d[0] = d;
    for (int k = 1; k < STAGES; k++) stg_d[k] = stg_q[k-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
    end else begin
      for (int k = 0; k < STAGES; k++) stg_q[k] <= stg_d[k];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] pin_s,
  input  logic [W-1:0] kind,
  input  logic [W-1:0] pol,
  input  logic [W-1:0] type_chg,
  input  logic [W-1:0] ack,
  output logic [W-1:0] raw
);
  logic [W-1:0] prev_q, evt_q, evt_d;
  logic [W-1:0] rise, fall, hit;

  always_comb begin
    rise  = pin_s & ~prev_q;
    fall  = ~pin_s & prev_q;
    hit   = kind & ((pol & rise) | (~pol & fall));
    evt_d = ((evt_q & ~ack) | hit) & ~type_chg;
    raw   = (~kind & ~(pol ^ pin_s)) | (kind & evt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      evt_q  <= '0;
    end else begin
      prev_q <= pin_s;
      evt_q  <= evt_d;
    end
  end

  // R3: a latched event persists while neither acknowledged nor retyped
  a_r3_event_holds: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt_q & ~ack & ~type_chg) != '0) |=>
      ((evt_q & $past(evt_q & ~ack & ~type_chg)) == $past(evt_q & ~ack & ~type_chg)));

  // R4: acknowledge clears unless an edge arrives in the same cycle
  a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    ((ack & ~hit) != '0) |=> ((evt_q & $past(ack & ~hit)) == '0));

  // R4: a new edge is never lost to a simultaneous acknowledge
  a_r4_new_edge_wins: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & ~type_chg) != '0) |=> ((evt_q & $past(hit & ~type_chg)) == $past(hit & ~type_chg)));

  // R5: a type change always leaves the event cleared
  a_r5_type_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (type_chg != '0) |=> ((evt_q & $past(type_chg)) == '0));
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  input  logic [W-1:0]      pin_s,
  input  logic [W-1:0]      raw,
  output logic [W-1:0]      dir_q,
  output logic [W-1:0]      out_q,
  output logic [W-1:0]      kind_q,
  output logic [W-1:0]      pol_q,
  output logic [W-1:0]      ien_q,
  output logic [W-1:0]      type_chg,
  output logic [W-1:0]      ack
);
  logic       wr_en;
  reg_addr_e  a;
  logic [W-1:0] dir_d, out_d, kind_d, pol_d, ien_d;
  logic [W-1:0] data_view;

  always_comb begin
    wr_en    = bus_sel & bus_wr;
    a        = reg_addr_e'(bus_addr);
    dir_d    = dir_q;
    out_d    = out_q;
    kind_d   = kind_q;
    pol_d    = pol_q;
    ien_d    = ien_q;
    type_chg = '0;
    ack      = '0;
    if (wr_en) begin
      case (a)
        REG_DATA: out_d  = bus_wdata;
        REG_DIR:  dir_d  = bus_wdata;
        REG_KIND: begin kind_d = bus_wdata; type_chg = bus_wdata ^ kind_q; end
        REG_POL:  begin pol_d  = bus_wdata; type_chg = bus_wdata ^ pol_q;  end
        REG_IEN:  ien_d  = bus_wdata;
        REG_ACK:  ack    = bus_wdata;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '0;
      out_q  <= '0;
      kind_q <= '0;
      pol_q  <= '0;
      ien_q  <= '0;
    end else begin
      dir_q  <= dir_d;
      out_q  <= out_d;
      kind_q <= kind_d;
      pol_q  <= pol_d;
      ien_q  <= ien_d;
    end
  end

  always_comb begin
    data_view = (dir_q & out_q) | (~dir_q & pin_s);
    bus_rdata = '0;
    if (bus_sel) begin
      case (a)
        REG_DATA: bus_rdata = data_view;
        REG_DIR:  bus_rdata = dir_q;
        REG_KIND: bus_rdata = kind_q;
        REG_POL:  bus_rdata = pol_q;
        REG_IEN:  bus_rdata = ien_q;
        REG_RAW:  bus_rdata = raw;
        REG_STAT: bus_rdata = raw & ien_q;
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R8: a direction write lands on the next edge
  a_r8_dir_write: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == REG_DIR) |=> (dir_q == $past(bus_wdata)));
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W           = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      pin_i,
  output logic [W-1:0]      pin_o,
  output logic [W-1:0]      pin_oe,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [W-1:0]      bus_wdata,
  output logic [W-1:0]      bus_rdata,
  output logic              irq_o,
  output logic [W-1:0]      irq_pin_o
);
  logic [W-1:0] pin_s, raw;
  logic [W-1:0] dir_q, out_q, kind_q, pol_q, ien_q, type_chg, ack;

  gpio_sync #(.W(W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pin_s)
  );

  gpio_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_s(pin_s), .raw(raw),
    .dir_q(dir_q), .out_q(out_q), .kind_q(kind_q), .pol_q(pol_q),
    .ien_q(ien_q), .type_chg(type_chg), .ack(ack)
  );

  gpio_irq_detect #(.W(W)) u_det (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .kind(kind_q), .pol(pol_q),
    .type_chg(type_chg), .ack(ack), .raw(raw)
  );

  assign pin_oe    = dir_q;
  assign pin_o     = out_q;
  assign irq_pin_o = raw & ien_q;
  assign irq_o     = |irq_pin_o;

  // R6: an enable write of zero silences every pin on the next edge
  a_r6_disable_silences: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_addr == REG_IEN && bus_wdata == '0) |=> (irq_pin_o == '0));

  // R7: a combined request implies at least one pin request
  a_r7_any_pin: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($countones(irq_pin_o) > 0));
endmodule

// File: tb/gpio_irq_port_test.sv
module gpio_irq_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pin_i = 8'h00;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0] bus_addr = 3'd0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] pin_o, pin_oe, bus_rdata, irq_pin_o;
  logic       irq_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic running = 1'b0;

  // behavioural reference state
  logic [7:0] m_s1, m_s2, m_prev, m_evt, m_dir, m_out, m_kind, m_pol, m_ien;

  gpio_irq_port uut (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_o(irq_o), .irq_pin_o(irq_pin_o)
  );

  always #10 clk = ~clk;

  task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at cycle %0d", tag, got, exp, cyc);
    end
  endtask

  function automatic logic [7:0] m_raw();
    logic [7:0] r;
    for (int i = 0; i < 8; i++)
      r[i] = m_kind[i] ? m_evt[i] : (m_pol[i] ? m_s2[i] : !m_s2[i]);
    return r;
  endfunction

  function automatic logic [7:0] m_rdata();
    if (!bus_sel) return 8'h00;
    case (bus_addr)
      3'd0: return (m_dir & m_out) | (~m_dir & m_s2);
      3'd1: return m_dir;
      3'd2: return m_kind;
      3'd3: return m_pol;
      3'd4: return m_ien;
      3'd5: return m_raw();
      3'd6: return m_raw() & m_ien;
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_evt <= 0;
      m_dir <= 0; m_out <= 0; m_kind <= 0; m_pol <= 0; m_ien <= 0;
    end else begin : upd
      logic [7:0] ne;
      logic w;
      w = bus_sel && bus_wr;
      for (int i = 0; i < 8; i++) begin
        logic edge_seen, chg, ackb;
        edge_seen = m_kind[i] && (m_pol[i] ? (m_s2[i] && !m_prev[i]) : (!m_s2[i] && m_prev[i]));
        chg  = (w && bus_addr == 3'd2 && bus_wdata[i] != m_kind[i]) ||
               (w && bus_addr == 3'd3 && bus_wdata[i] != m_pol[i]);
        ackb = w && bus_addr == 3'd7 && bus_wdata[i];
        if (chg) ne[i] = 1'b0;
        else if (edge_seen) ne[i] = 1'b1;
        else if (ackb) ne[i] = 1'b0;
        else ne[i] = m_evt[i];
      end
      m_evt <= ne;
      if (w) case (bus_addr)
        3'd0: m_out  <= bus_wdata;
        3'd1: m_dir  <= bus_wdata;
        3'd2: m_kind <= bus_wdata;
        3'd3: m_pol  <= bus_wdata;
        3'd4: m_ien  <= bus_wdata;
        default: ;
      endcase
      m_prev <= m_s2; m_s2 <= m_s1; m_s1 <= pin_i;
    end
  end

  // per-cycle comparison against the model, away from the active edge
  always @(negedge clk) begin
    if (running && rst_n) begin
      check("R6 irq_pin_o", irq_pin_o, m_raw() & m_ien);
      check("R7 irq_o", {7'd0, irq_o}, {7'd0, |(m_raw() & m_ien)});
      check("R8 pin_oe", pin_oe, m_dir);
      check("R8 pin_o", pin_o, m_out);
      check("R10 bus_rdata", bus_rdata, m_rdata());
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_fail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic put(input logic s, input logic w, input logic [2:0] a, input logic [7:0] d);
    #1;
    bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
  endtask

  task automatic go();
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    put(1, 1, a, d); go(); put(0, 0, 3'd0, 8'h00);
  endtask

  function automatic logic [31:0] xs(input logic [31:0] v);
    logic [31:0] t;
    t = v ^ (v << 13); t = t ^ (t >> 17); t = t ^ (t << 5);
    return t;
  endfunction

  initial begin
    logic [31:0] rng;
    rng = 32'h1ACE_B00C;
    repeat (3) go();
    #1 rst_n = 1'b1;
    running = 1'b1;
    go();
    // R11 reset state
    check("R11 irq_o after reset", {7'd0, irq_o}, 8'h00);
    check("R11 pin_oe after reset", pin_oe, 8'h00);
    put(1, 0, 3'd2, 8'h00); go();
    check("R11 kind reg after reset", bus_rdata, 8'h00);

    // R8 direction and output
    wr(3'd1, 8'hF0);
    wr(3'd0, 8'hA5);
    check("R8 pin_oe", pin_oe, 8'hF0);
    check("R8 pin_o", pin_o, 8'hA5);

    // R1 / R9 synchroniser latency and data read mix
    put(1, 0, 3'd0, 8'h00); pin_i = 8'h0C; go();
    check("R1 one edge not yet visible", bus_rdata, 8'hA0);
    go();
    check("R9 data read after two edges", bus_rdata, 8'hAC);

    // R2 level-low on pin0 (pin0 is 0)
    wr(3'd4, 8'h01);
    check("R2 level low active", irq_pin_o, 8'h01);
    put(0, 0, 3'd0, 8'h00); pin_i = 8'h0D; go();
    check("R2 still active one edge later", irq_pin_o, 8'h01);
    go();
    check("R2 released after sync", irq_pin_o, 8'h00);

    // R3 rising edge on pin1
    wr(3'd2, 8'h02);
    wr(3'd3, 8'h02);
    wr(3'd4, 8'h02);
    put(0, 0, 3'd0, 8'h00); pin_i = 8'h0F; go(); go();
    check("R3 no event before third edge", irq_pin_o, 8'h00);
    go();
    check("R3 rising edge latched", irq_pin_o, 8'h02);
    put(0, 0, 3'd0, 8'h00); pin_i = 8'h0D; go(); go(); go();
    check("R3 event held after pin returns", irq_pin_o, 8'h02);

    // R4 acknowledge
    wr(3'd7, 8'h02);
    check("R4 ack clears", irq_pin_o, 8'h00);
    // R4 acknowledge on the same edge as a new detected edge
    put(0, 0, 3'd0, 8'h00); pin_i = 8'h0F; go(); go();
    wr(3'd7, 8'h02);
    check("R4 new edge wins over ack", irq_pin_o, 8'h02);

    // R5 type change clears
    put(0, 0, 3'd0, 8'h00); pin_i = 8'h0D; go(); go(); go();
    wr(3'd3, 8'h00);
    check("R5 polarity change clears event", irq_pin_o, 8'h00);
    go();
    check("R5 no false event after change", irq_pin_o, 8'h00);

    // R6 / R7 / R10
    wr(3'd2, 8'h00);
    wr(3'd4, 8'h00);
    check("R6 disabled pin silent", irq_pin_o, 8'h00);
    wr(3'd4, 8'h02);
    check("R7 combined request", {7'd0, irq_o}, 8'h01);
    put(1, 0, 3'd5, 8'h00); go();
    check("R10 raw read", bus_rdata, 8'hF2);
    put(1, 0, 3'd6, 8'h00); go();
    check("R10 status read", bus_rdata, 8'h02);
    put(1, 0, 3'd7, 8'h00); go();
    check("R10 ack reads zero", bus_rdata, 8'h00);

    // pseudo-random traffic compared each cycle against the model
    for (int n = 0; n < 4000; n++) begin
      rng = xs(rng);
      #1;
      bus_sel   = rng[0] | rng[1];
      bus_wr    = rng[2] & rng[3];
      bus_addr  = rng[6:4];
      bus_wdata = rng[15:8];
      if (rng[16]) pin_i = pin_i ^ rng[31:24];
      go();
    end

    running = 1'b0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule